// File: doc/BRIEF.md
# Fixed-Period Single-Reference Bridge Switching Controller

This block drives the four switches of a single-phase full-bridge inverter as two diagonal pairs. One pair (positive bridge state) connects the DC link so that the inductor current is driven positive. The other pair (negative bridge state) drives it negative. There is no hysteresis band. A single-bit comparator tells the block whether the current reference lies above the measured inductor current. A half-cycle flag from an external grid-tracking loop tells it which grid half cycle is in progress.

A free-running period counter marks fixed period boundaries. At every boundary the block starts a "timer state": the negative state in the positive half cycle, the positive state in the negative half cycle. The comparator then ends that state as soon as the current crosses the reference, and the opposite state holds until the next boundary. One edge per period therefore comes from the counter and the other from the comparator, which keeps the switching frequency fixed. The half-cycle flag is sampled only at boundaries.

The comparator input is synchronized and filtered before use. Every change between the two pairs passes through a fixed dead gap in which all four gates are off. Lowering the enable clears the bridge at once. After enable rises, operation restarts at a fresh period boundary.

Top module: `qff_hyst_ctrl`

## Requirements
- R1: While the synchronized reset is active or `en` is low, both gate outputs are 0; `en` sampled low at a clock edge turns both gates off at that edge.
- R2: `gate_pos` and `gate_neg` are never 1 in the same cycle.
- R3: Between one pair turning off and any pair turning on during continuous enable, both gates stay off for exactly DEAD_CYC cycles.
- R4: With latched half-cycle 1, each period boundary starts the negative state. It ends when the filtered `cmp_in` is 1 (`cmp_in` = 1 means reference above measured current). `gate_neg` falls FILT_LEN+4 cycles after `cmp_in` changes.
- R5: With latched half-cycle 0, each period boundary starts the positive state. It ends when the filtered `cmp_in` is 0. `gate_pos` falls FILT_LEN+4 cycles after `cmp_in` changes.
- R6: Turn-on instants of the timer state fall on period boundaries, so while the comparator ends that state in every period they are exactly PERIOD_CYC cycles apart.
- R7: A `cmp_in` pulse shorter than FILT_LEN cycles causes no change at the gates.
- R8: `half_pos` is latched only at period boundaries; until the next boundary the comparator rule of the previous half cycle applies.
- R9: A boundary whose selected state equals the state already applied causes no off gap. This includes the case where the comparator condition already holds at the boundary, in which case the block goes straight to the opposite state.
- R10: The first period boundary occurs in the cycle `en` is first sampled high. The state chosen there turns on DEAD_CYC+1 cycles after the input change.
- R11: Driving a current loop, the bridge keeps the inductor current near the reference in either half cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Active-high run enable; low forces all gates off |
| half_pos | input | 1 | Grid half-cycle flag, 1 in the positive half cycle |
| cmp_in | input | 1 | Asynchronous comparator result, 1 when reference exceeds measured current |
| gate_pos | output | 1 | Gate command for the pair that applies the positive bridge state |
| gate_neg | output | 1 | Gate command for the pair that applies the negative bridge state |

## Verification
Directed open-loop comparator levels give exact answers for each polarity. They show when the counter starts the state, when the comparator ends it and with what latency, whether a short glitch is rejected, and whether a mid-period polarity change is deferred to the boundary. A closed loop then models an inductor whose slope depends on the bridge state and the half cycle. The loop runs with random reference steps, random half-cycle changes and random segment lengths. This separates boundary-aligned timer starts from comparator-driven ends, and it exercises the dead gap and pair exclusion under dense switching. The tracking error at the end of each segment shows whether the two edges are assigned to the right states for the half cycle in progress.

// File: rtl/qff_pkg.sv
`timescale 1ns/1ps
package qff_pkg;
  typedef enum logic [1:0] {
    BR_OFF = 2'd0,
    BR_POS = 2'd1,
    BR_NEG = 2'd2
  } bridge_e;
endpackage

// File: rtl/qff_cmp_cond.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a persistence filter on the comparator.
module qff_cmp_cond #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  output logic cmp_filt
);
  logic sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= cmp_raw;
      sync2_q <= sync1_q;
    end
  end

  generate
    if (FILT_LEN <= 1) begin : g_nofilt
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= sync2_q;
      end
      assign cmp_filt = lvl_q;
    end else begin : g_filt
      localparam int FW = $clog2(FILT_LEN + 1);
      localparam logic [FW-1:0] LIM = FW'(FILT_LEN - 1);
      logic          lvl_q, lvl_d;
      logic [FW-1:0] run_q, run_d;

      always_comb begin
        lvl_d = lvl_q;
        run_d = '0;
        if (sync2_q != lvl_q) begin
          if (run_q == LIM) begin
            lvl_d = sync2_q;
          end else begin
            run_d = run_q + 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_q <= 1'b0;
          run_q <= '0;
        end else begin
          lvl_q <= lvl_d;
          run_q <= run_d;
        end
      end
      assign cmp_filt = lvl_q;
    end
  endgenerate
endmodule

// File: rtl/qff_period_timer.sv
`timescale 1ns/1ps
// Free-running period counter; tick marks a period boundary.
module qff_period_timer #(
  parameter int PERIOD_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en & (~run_q | (cnt_q == LAST));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!en) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else begin
      run_d = 1'b1;
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/qff_switch_seq.sv
`timescale 1ns/1ps
// Chooses the requested bridge state: timer start at boundaries, comparator end inside.
module qff_switch_seq
  import qff_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    tick,
  input  logic    half_pos,
  input  logic    cmp_filt,
  output logic    pol,
  output bridge_e req
);
  logic    pol_q, pol_d;
  bridge_e req_q, req_d;
  bridge_e tmr_st, oth_st;
  logic    use_pol, end_now;

  always_comb begin
    use_pol = tick ? half_pos : pol_q;
    tmr_st  = use_pol ? BR_NEG : BR_POS;
    oth_st  = use_pol ? BR_POS : BR_NEG;
    end_now = use_pol ? cmp_filt : ~cmp_filt;
    pol_d   = pol_q;
    req_d   = req_q;
    if (!en) begin
      req_d = BR_OFF;
    end else if (tick) begin
      pol_d = half_pos;
      req_d = end_now ? oth_st : tmr_st;
    end else if ((req_q == tmr_st) && end_now) begin
      req_d = oth_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b1;
      req_q <= BR_OFF;
    end else begin
      pol_q <= pol_d;
      req_q <= req_d;
    end
  end

  assign pol = pol_q;
  assign req = req_q;
endmodule

// File: rtl/qff_deadtime.sv
`timescale 1ns/1ps
// Applies the requested state with a fixed all-off gap between states.
module qff_deadtime
  import qff_pkg::*;
#(
  parameter int DEAD_CYC = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  bridge_e req,
  output logic    gate_pos,
  output logic    gate_neg
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] LIM = DW'(DEAD_CYC - 1);

  bridge_e       cur_q, cur_d;
  logic [DW-1:0] off_q, off_d;

  always_comb begin
    cur_d = cur_q;
    off_d = off_q;
    if (!en) begin
      cur_d = BR_OFF;
      off_d = '0;
    end else if (cur_q == BR_OFF) begin
      if (req != BR_OFF) begin
        if (off_q == LIM) begin
          cur_d = req;
          off_d = '0;
        end else begin
          off_d = off_q + 1'b1;
        end
      end
    end else if (req != cur_q) begin
      cur_d = BR_OFF;
      off_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= BR_OFF;
      off_q <= '0;
    end else begin
      cur_q <= cur_d;
      off_q <= off_d;
    end
  end

  assign gate_pos = (cur_q == BR_POS);
  assign gate_neg = (cur_q == BR_NEG);
endmodule

// File: rtl/qff_hyst_ctrl.sv
`timescale 1ns/1ps
module qff_hyst_ctrl
  import qff_pkg::*;
#(
  parameter int PERIOD_CYC = 5000,
  parameter int DEAD_CYC   = 20,
  parameter int FILT_LEN   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic half_pos,
  input  logic cmp_in,
  output logic gate_pos,
  output logic gate_neg
);
  logic    rs1_q, rst_s;
  logic    cmp_f, tick, pol_q;
  bridge_e req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  qff_cmp_cond #(.FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst_n(rst_s), .cmp_raw(cmp_in), .cmp_filt(cmp_f)
  );

  qff_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_s), .en(en), .tick(tick)
  );

  qff_switch_seq u_seq (
    .clk(clk), .rst_n(rst_s), .en(en), .tick(tick), .half_pos(half_pos),
    .cmp_filt(cmp_f), .pol(pol_q), .req(req)
  );

  qff_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk(clk), .rst_n(rst_s), .en(en), .req(req),
    .gate_pos(gate_pos), .gate_neg(gate_neg)
  );
endmodule

// File: rtl/qff_hyst_chk.sv
`timescale 1ns/1ps
module qff_hyst_chk #(
  parameter int DEAD_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tick,
  input logic pol,
  input logic half_pos,
  input logic gate_pos,
  input logic gate_neg
);
  localparam int OW = $clog2(DEAD_CYC + 2);
  localparam logic [OW-1:0] OMAX = {OW{1'b1}};

  logic [1:0]    last_q;
  logic [OW-1:0] offc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 2'd0;
      offc_q <= '0;
    end else if (!en) begin
      last_q <= 2'd0;
      offc_q <= '0;
    end else if (gate_pos) begin
      last_q <= 2'd1;
      offc_q <= '0;
    end else if (gate_neg) begin
      last_q <= 2'd2;
      offc_q <= '0;
    end else if (offc_q != OMAX) begin
      offc_q <= offc_q + 1'b1;
    end
  end

  // R2
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_pos && gate_neg));

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_pos && !gate_neg));

  // R3
  dead_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_pos) && (last_q != 2'd0)) |-> (offc_q == OW'(DEAD_CYC)));

  // R3
  dead_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_neg) && (last_q != 2'd0)) |-> (offc_q == OW'(DEAD_CYC)));

  // R8
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pol));

  // R8
  pol_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pol == $past(half_pos)));
endmodule

bind qff_hyst_ctrl qff_hyst_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_s), .en(en), .tick(tick), .pol(pol_q),
  .half_pos(half_pos), .gate_pos(gate_pos), .gate_neg(gate_neg)
);

// File: tb/tb_qff_hyst_ctrl.sv
`timescale 1ns/1ps
module tb_qff_hyst_ctrl;
  localparam int PER = 200;
  localparam int DT  = 4;
  localparam int FL  = 3;

  logic clk = 1'b0;
  logic rst_n, en, half_pos, cmp_in;
  logic gate_pos, gate_neg;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit loop_on = 1'b0;
  bit cmp_man = 1'b1;
  int i_lvl = 4000;
  int ref_lvl = 4000;
  int ov_cnt = 0;

  qff_hyst_ctrl #(.PERIOD_CYC(PER), .DEAD_CYC(DT), .FILT_LEN(FL)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .half_pos(half_pos), .cmp_in(cmp_in),
    .gate_pos(gate_pos), .gate_neg(gate_neg)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // inductor model: slope depends on bridge state and half cycle
  initial cmp_in = 1'b1;
  always @(negedge clk) begin
    if (loop_on) begin
      if (gate_pos) i_lvl = i_lvl + (half_pos ? 2 : 6);
      else if (gate_neg) i_lvl = i_lvl - (half_pos ? 6 : 2);
      cmp_in = (ref_lvl > i_lvl);
    end else begin
      cmp_in = cmp_man;
    end
  end

  // monitors: exclusion, dead gap, boundary spacing
  int last_act = 0, offc = 0, last_rise = -1, p_chg = 0;
  bit prev_any = 0, prev_tg = 0, p_prev = 0;
  always @(negedge clk) begin
    if (half_pos != p_prev) begin
      p_chg = cyc;
      last_rise = -1;
    end
    p_prev = half_pos;
    if (!rst_n || !en) begin
      last_act = 0; offc = 0; prev_any = 0; prev_tg = 0; last_rise = -1;
    end else begin
      bit any, tg;
      if (gate_pos && gate_neg) ov_cnt++;
      any = gate_pos | gate_neg;
      if (any && !prev_any && last_act != 0)
        chk(offc == DT, "R3 dead gap length", offc, DT);
      if (any) begin
        last_act = gate_pos ? 1 : 2;
        offc = 0;
      end else begin
        offc++;
      end
      prev_any = any;
      tg = half_pos ? gate_neg : gate_pos;
      if (loop_on && tg && !prev_tg && (cyc - p_chg >= 2*PER)) begin
        if (last_rise >= 0)
          chk(((cyc - last_rise) % PER) == 0, "R6 timer start spacing", cyc - last_rise, PER);
        last_rise = cyc;
      end
      prev_tg = tg;
    end
  end

  task automatic wait_gate(input bit on_pos, input bit lvl, input int lim, output int t);
    t = -1;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if ((on_pos ? gate_pos : gate_neg) == lvl) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic count_off(input bit on_pos, input int n, output int offs);
    offs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!(on_pos ? gate_pos : gate_neg)) offs++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int c, t, t2, t_a, r1, r2, offs;
    void'($urandom(32'd20555));
    rst_n = 1'b0; en = 1'b0; half_pos = 1'b0; cmp_man = 1'b1;
    repeat (5) @(negedge clk);
    chk(!gate_pos && !gate_neg, "R1 gates off in reset", {gate_pos, gate_neg}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!gate_pos && !gate_neg, "R1 gates off while disabled", {gate_pos, gate_neg}, 0);

    // R10 startup, half cycle 0, current below reference
    en = 1'b1; c = cyc;
    wait_gate(1'b1, 1'b1, 50, t);
    chk(t - c == DT + 1, "R10 first state turn-on delay", t - c, DT + 1);
    chk(!gate_neg, "R10 only timer pair on", gate_neg, 0);

    // R9 unended state carries across boundaries without a gap
    count_off(1'b1, 3*PER, offs);
    chk(offs == 0, "R9 held positive state across boundaries", offs, 0);

    // R5 comparator ends positive state
    cmp_man = 1'b0; c = cyc;
    wait_gate(1'b1, 1'b0, 100, t);
    chk(t - c == FL + 4, "R5 comparator end latency", t - c, FL + 4);
    wait_gate(1'b0, 1'b1, 100, t2);
    chk(t2 - t == DT, "R3 gap before negative state", t2 - t, DT);
    count_off(1'b0, 2*PER, offs);
    chk(offs == 0, "R9 condition holds at boundary, no gap", offs, 0);

    // R5 timer restarts positive state at a boundary
    cmp_man = 1'b1;
    wait_gate(1'b1, 1'b1, PER + 20, t_a);
    chk(t_a > 0, "R5 timer restarts positive state", t_a, 1);

    // R7 short glitch ignored
    cmp_man = 1'b0;
    repeat (FL - 1) @(negedge clk);
    cmp_man = 1'b1;
    count_off(1'b1, 30, offs);
    chk(offs == 0, "R7 glitch shorter than filter ignored", offs, 0);

    // R8 half cycle change mid-period: old rule until boundary
    half_pos = 1'b1; cmp_man = 1'b0; c = cyc;
    wait_gate(1'b1, 1'b0, 100, t);
    chk(t - c == FL + 4, "R8 previous polarity rule still applied", t - c, FL + 4);
    wait_gate(1'b0, 1'b1, 50, t2);
    count_off(1'b0, t_a + PER + 10 - cyc, offs);
    chk(offs == 0, "R9 negative state kept through boundary", offs, 0);

    // R4 comparator ends negative state under half cycle 1
    cmp_man = 1'b1; c = cyc;
    wait_gate(1'b0, 1'b0, 100, t);
    chk(t - c == FL + 4, "R4 comparator end latency", t - c, FL + 4);
    repeat (20) @(negedge clk);
    cmp_man = 1'b0;
    wait_gate(1'b0, 1'b1, PER + 20, r1);
    chk(r1 > 0 && ((r1 - t_a) % PER) == 0, "R6 start on boundary grid", (r1 - t_a) % PER, 0);
    repeat (30) @(negedge clk);
    cmp_man = 1'b1;
    repeat (30) @(negedge clk);
    cmp_man = 1'b0;
    wait_gate(1'b0, 1'b1, PER + 20, r2);
    chk(r2 - r1 == PER, "R6 one period between timer starts", r2 - r1, PER);

    // R1 disable clears gates on the next edge
    en = 1'b0; c = cyc;
    @(negedge clk);
    chk(!gate_pos && !gate_neg && cyc == c + 1, "R1 disable response", {gate_pos, gate_neg}, 0);

    // R10 restart in half cycle 1 with condition already true
    cmp_man = 1'b1;
    repeat (12) @(negedge clk);
    en = 1'b1; c = cyc;
    wait_gate(1'b1, 1'b1, 50, t);
    chk(t - c == DT + 1, "R10 restart goes straight to positive", t - c, DT + 1);
    chk(!gate_neg, "R10 no negative state at restart", gate_neg, 0);
    en = 1'b0;
    repeat (5) @(negedge clk);

    // R11 closed loop with random reference steps and half cycles
    i_lvl = 4000; ref_lvl = 4000; loop_on = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b1;
    for (int s = 0; s < 30; s++) begin
      int step, dur, err;
      half_pos = ($urandom_range(0, 1) == 1);
      step = $urandom_range(0, 1600);
      ref_lvl = ref_lvl + step - 800;
      if (ref_lvl < 2000) ref_lvl = 2000;
      if (ref_lvl > 6000) ref_lvl = 6000;
      dur = $urandom_range(4*PER, 6*PER);
      repeat (dur) @(negedge clk);
      err = i_lvl - ref_lvl;
      if (err < 0) err = -err;
      chk(err <= 1000, half_pos ? "R11 tracking, half cycle 1" : "R11 tracking, half cycle 0", err, 1000);
    end
    en = 1'b0;
    repeat (5) @(negedge clk);
    chk(ov_cnt == 0, "R2 pairs never on together", ov_cnt, 0);
    summary();
  end
endmodule